// File: doc/BRIEF.md
# Width-Scaled Address Generation Unit

This block forms byte addresses for a load/store datapath. Each request names an addressing mode, an access width (8, 16, 32 or 64 bits) and the operands that mode needs: an address register as base, an index address register, an offset register, and a short and a word immediate. The block returns the effective byte address, a one-hot width strobe for memory, and a flag when the address is not a multiple of the access size. Register-derived offsets are multiplied by the access size in bytes. Immediate displacements are added as they are. Post-modify and stack modes write the updated pointer back into the block's own register file.

The request side is a valid/ready stream. `req_ready` follows `mem_ready`, so the memory applies back-pressure. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. While `req_valid` is high the request fields must stay stable, and pointer write-back happens only on the transfer edge. `mem_valid` is `req_valid` with illegal requests masked out. A separate plain write port loads the address, offset and stack registers.

Top module: `scaled_agu`

## Requirements
- R1: `mem_width` is one-hot while `req_valid` is high. Width code 0 sets bit 0 (8 bit), code 1 sets bit 1 (16 bit), code 2 sets bit 2 (32 bit) and code 3 sets bit 3 (64 bit). It is all zero when `req_valid` is low.
- R2: Mode 0 (post-increment) and mode 1 (post-decrement) give the base register as address and then step it by +1/+2/+4/+8 or -1/-2/-4/-8 for width codes 0..3.
- R3: Mode 2 (post-offset) gives the base as address and then adds offset register `req_ni` times 1/2/4/8 to the base register.
- R4: Mode 3 gives base plus offset register 0 times 1/2/4/8 and writes nothing back.
- R5: Mode 4 gives base plus address register `req_rm` times 1/2/4/8 and writes nothing back.
- R6: Mode 5 adds `req_disp_s`, sign-extended. Mode 6 adds `req_disp_w`, sign-extended. Neither is scaled by width, and neither writes back.
- R7: Mode 7 (push) gives the stack pointer as address and then adds 8 to it. Mode 8 (pop) subtracts 8 first and uses the result as both address and new stack pointer. Both step by 8 at every width.
- R8: Mode 9 gives the stack pointer minus zero-extended `req_disp_s` and is legal only at width codes 1 and 2. Mode 10 gives the stack pointer plus sign-extended `req_disp_w`. An illegal request raises `mem_illegal`, holds `mem_valid` low and changes no register. Mode codes 11..15 are illegal too.
- R9: `mem_misalign` is high for a legal valid request whose address modulo the access size in bytes is non-zero.
- R10: `req_ready` equals `mem_ready`. No pointer write-back happens without a transfer.
- R11: The write port loads an address register (kind 0), an offset register (kind 1) or the stack pointer (kind 2). When it targets the same register as a write-back on the same edge, the port value wins.
- R12: After reset every register reads zero.
- R13: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register load strobe |
| wr_kind | input | 2 | Load target: 0 address, 1 offset, 2 stack pointer |
| wr_idx | input | 3 | Register index for the load |
| wr_data | input | 32 | Load value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (follows mem_ready) |
| req_mode | input | 4 | Addressing mode code |
| req_width | input | 2 | Access width code |
| req_areg | input | 3 | Base address register |
| req_rm | input | 3 | Index address register |
| req_ni | input | 2 | Offset register for post-offset mode |
| req_disp_s | input | 8 | Short immediate |
| req_disp_w | input | 16 | Word immediate |
| mem_ready | input | 1 | Memory accepts the access |
| mem_valid | output | 1 | Legal access presented to memory |
| mem_addr | output | 32 | Effective byte address |
| mem_width | output | 4 | One-hot access width |
| mem_misalign | output | 1 | Address not aligned to the width |
| mem_illegal | output | 1 | Mode not allowed at this width |

## Verification
The hardest case to observe is a pointer write-back that is wrong or missing. The bad value shows up only in a later access, and only if that access uses the same register. After every accepted post-modify or stack request, the bench therefore issues a zero-displacement read of the affected pointer and compares it with its own shadow register. It also makes these reads after requests that were stalled or illegal. The sweep covers every mode at every width over four base alignments, so each scale factor and misalignment pattern is reached.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [3:0] {
    M_POST_INC = 4'd0, M_POST_DEC = 4'd1, M_POST_OFS = 4'd2, M_IDX_N0 = 4'd3,
    M_IDX_RM   = 4'd4, M_DISP_S   = 4'd5, M_DISP_W   = 4'd6, M_PUSH   = 4'd7,
    M_POP      = 4'd8, M_SP_S     = 4'd9, M_SP_W     = 4'd10
  } agu_mode_e;

  typedef enum logic [1:0] {W_BYTE = 2'd0, W_WORD = 2'd1, W_LONG = 2'd2, W_DLONG = 2'd3} agu_width_e;
  typedef enum logic [1:0] {WB_NONE = 2'd0, WB_AREG = 2'd1, WB_SP = 2'd2} agu_wb_e;
  typedef enum logic [1:0] {K_AREG = 2'd0, K_NREG = 2'd1, K_SP = 2'd2} agu_kind_e;
endpackage

// File: rtl/agu_regfile.sv
module agu_regfile
  import agu_pkg::*;
#(
  parameter int AW  = 32,
  parameter int NA  = 8,
  parameter int NN  = 4,
  localparam int AIW = $clog2(NA),
  localparam int NIW = $clog2(NN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_kind,
  input  logic [AIW-1:0] wr_idx,
  input  logic [AW-1:0]  wr_data,
  input  logic           wb_en,
  input  agu_wb_e        wb_kind,
  input  logic [AIW-1:0] wb_idx,
  input  logic [AW-1:0]  wb_data,
  input  logic [AIW-1:0] rd_a_idx,
  input  logic [AIW-1:0] rd_m_idx,
  input  logic [NIW-1:0] rd_n_idx,
  output logic [AW-1:0]  rd_a,
  output logic [AW-1:0]  rd_m,
  output logic [AW-1:0]  rd_n,
  output logic [AW-1:0]  rd_n0,
  output logic [AW-1:0]  sp_val
);
  logic [AW-1:0] areg [NA];
  logic [AW-1:0] nreg [NN];
  logic [AW-1:0] sp_q;
  logic          n_hit;

  assign n_hit = ({1'b0, wr_idx} < (AIW+1)'(NN));

  // The port load comes after the write-back, so it wins on a collision.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NA; i++) areg[i] <= '0;
      for (int i = 0; i < NN; i++) nreg[i] <= '0;
      sp_q <= '0;
    end else begin
      if (wb_en && wb_kind == WB_AREG) areg[wb_idx] <= wb_data;
      if (wb_en && wb_kind == WB_SP)   sp_q <= wb_data;
      if (wr_en) begin
        case (wr_kind)
          K_AREG:  areg[wr_idx] <= wr_data;
          K_NREG:  if (n_hit) nreg[wr_idx[NIW-1:0]] <= wr_data;
          K_SP:    sp_q <= wr_data;
          default: ;
        endcase
      end
    end
  end

  assign rd_a   = areg[rd_a_idx];
  assign rd_m   = areg[rd_m_idx];
  assign rd_n   = nreg[rd_n_idx];
  assign rd_n0  = nreg[0];
  assign sp_val = sp_q;

  // R11: a stack-pointer load always lands, whatever the write-back did
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == K_SP) |=> sp_q == $past(wr_data));
endmodule

// File: rtl/agu_ea_calc.sv
module agu_ea_calc
  import agu_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DSW = 8,
  parameter int DWW = 16
) (
  input  logic [3:0]     mode,
  input  logic [1:0]     width,
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  idx_m,
  input  logic [AW-1:0]  ofs_n,
  input  logic [AW-1:0]  ofs_n0,
  input  logic [AW-1:0]  sp,
  input  logic [DSW-1:0] disp_s,
  input  logic [DWW-1:0] disp_w,
  output logic [AW-1:0]  ea,
  output logic [AW-1:0]  nxt,
  output agu_wb_e        wb_kind,
  output logic           illegal
);
  localparam logic [AW-1:0] SP_STEP = AW'(8);

  logic [AW-1:0] step, n_sc, n0_sc, m_sc, ds_sx, ds_zx, dw_sx;

  assign step  = AW'(1) << width;
  assign n_sc  = ofs_n  << width;
  assign n0_sc = ofs_n0 << width;
  assign m_sc  = idx_m  << width;
  assign ds_sx = {{(AW-DSW){disp_s[DSW-1]}}, disp_s};
  assign ds_zx = {{(AW-DSW){1'b0}}, disp_s};
  assign dw_sx = {{(AW-DWW){disp_w[DWW-1]}}, disp_w};

  always_comb begin
    ea      = base;
    nxt     = base;
    wb_kind = WB_NONE;
    illegal = 1'b0;
    case (mode)
      M_POST_INC: begin nxt = base + step; wb_kind = WB_AREG; end
      M_POST_DEC: begin nxt = base - step; wb_kind = WB_AREG; end
      M_POST_OFS: begin nxt = base + n_sc; wb_kind = WB_AREG; end
      M_IDX_N0:   ea = base + n0_sc;
      M_IDX_RM:   ea = base + m_sc;
      M_DISP_S:   ea = base + ds_sx;
      M_DISP_W:   ea = base + dw_sx;
      M_PUSH:     begin ea = sp; nxt = sp + SP_STEP; wb_kind = WB_SP; end
      M_POP:      begin ea = sp - SP_STEP; nxt = sp - SP_STEP; wb_kind = WB_SP; end
      M_SP_S: begin
        ea      = sp - ds_zx;
        illegal = (width == W_BYTE) || (width == W_DLONG);
      end
      M_SP_W:     ea = sp + dw_sx;
      default:    illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/agu_width_check.sv
module agu_width_check
  import agu_pkg::*;
#(
  parameter int NW = 4
) (
  input  logic [1:0]    width,
  input  logic [NW-2:0] ea_lo,
  output logic [NW-1:0] strobe,
  output logic          misalign
);
  logic [NW-2:0] mask;

  for (genvar g = 0; g < NW; g++) begin : g_strobe
    assign strobe[g] = (width == 2'(g));
  end

  assign mask     = (NW-1)'((1 << width) - 1);
  assign misalign = |(ea_lo & mask);
endmodule

// File: rtl/scaled_agu.sv
module scaled_agu
  import agu_pkg::*;
#(
  parameter int AW  = 32,
  parameter int NA  = 8,
  parameter int NN  = 4,
  parameter int DSW = 8,
  parameter int DWW = 16,
  localparam int AIW = $clog2(NA),
  localparam int NIW = $clog2(NN),
  localparam int NW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_kind,
  input  logic [AIW-1:0] wr_idx,
  input  logic [AW-1:0]  wr_data,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [3:0]     req_mode,
  input  logic [1:0]     req_width,
  input  logic [AIW-1:0] req_areg,
  input  logic [AIW-1:0] req_rm,
  input  logic [NIW-1:0] req_ni,
  input  logic [DSW-1:0] req_disp_s,
  input  logic [DWW-1:0] req_disp_w,
  input  logic           mem_ready,
  output logic           mem_valid,
  output logic [AW-1:0]  mem_addr,
  output logic [NW-1:0]  mem_width,
  output logic           mem_misalign,
  output logic           mem_illegal
);
  logic [AW-1:0] base, idx_m, ofs_n, ofs_n0, sp_val, ea, nxt;
  logic [NW-1:0] strobe;
  agu_wb_e       wb_kind;
  logic          illegal, misalign, xfer, wb_en;

  assign req_ready = mem_ready;
  assign xfer      = req_valid && mem_ready;
  assign wb_en     = xfer && !illegal && (wb_kind != WB_NONE);

  agu_regfile #(.AW(AW), .NA(NA), .NN(NN)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
    .wb_en(wb_en), .wb_kind(wb_kind), .wb_idx(req_areg), .wb_data(nxt),
    .rd_a_idx(req_areg), .rd_m_idx(req_rm), .rd_n_idx(req_ni),
    .rd_a(base), .rd_m(idx_m), .rd_n(ofs_n), .rd_n0(ofs_n0), .sp_val(sp_val)
  );

  agu_ea_calc #(.AW(AW), .DSW(DSW), .DWW(DWW)) u_calc (
    .mode(req_mode), .width(req_width), .base(base), .idx_m(idx_m),
    .ofs_n(ofs_n), .ofs_n0(ofs_n0), .sp(sp_val),
    .disp_s(req_disp_s), .disp_w(req_disp_w),
    .ea(ea), .nxt(nxt), .wb_kind(wb_kind), .illegal(illegal)
  );

  agu_width_check #(.NW(NW)) u_wchk (
    .width(req_width), .ea_lo(ea[NW-2:0]), .strobe(strobe), .misalign(misalign)
  );

  assign mem_addr     = ea;
  assign mem_valid    = req_valid && !illegal;
  assign mem_illegal  = req_valid && illegal;
  assign mem_width    = req_valid ? strobe : '0;
  assign mem_misalign = req_valid && !illegal && misalign;

  // R1: exactly one width line while a request is valid
  a_r1_width_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot(mem_width));

  // R7: a legal accepted push moves the stack pointer up by eight
  a_r7_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && req_mode == M_PUSH && !(wr_en && wr_kind == K_SP))
      |=> sp_val == $past(sp_val) + AW'(8));

  // R8: the illegal flag only appears for stack short displacement at byte/two-long or unknown modes
  a_r8_illegal_cause: assert property (@(posedge clk) disable iff (!rst_n)
    mem_illegal |-> ((req_mode == M_SP_S && (req_width == W_BYTE || req_width == W_DLONG))
                     || req_mode > M_SP_W));

  // R9: a byte access can never be misaligned
  a_r9_byte_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_misalign |-> mem_width != NW'(1));

  // R10: with no transfer and no load, the stack pointer holds
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ready && !wr_en) |=> $stable(sp_val));
endmodule

// File: tb/scaled_agu_tb.sv
module scaled_agu_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 0;
  logic [1:0]  wr_kind = 0;
  logic [2:0]  wr_idx = 0;
  logic [31:0] wr_data = 0;
  logic        req_valid = 0, mem_ready = 1;
  logic [3:0]  req_mode = 0;
  logic [1:0]  req_width = 0;
  logic [2:0]  req_areg = 0, req_rm = 0;
  logic [1:0]  req_ni = 0;
  logic [7:0]  req_disp_s = 0;
  logic [15:0] req_disp_w = 0;
  logic        req_ready, mem_valid, mem_misalign, mem_illegal;
  logic [31:0] mem_addr;
  logic [3:0]  mem_width;

  int errors = 0, checks = 0;
  logic [31:0] sa [8];
  logic [31:0] sn [4];
  logic [31:0] ssp;

  scaled_agu u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
    .wr_data(wr_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_width(req_width), .req_areg(req_areg), .req_rm(req_rm),
    .req_ni(req_ni), .req_disp_s(req_disp_s), .req_disp_w(req_disp_w),
    .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_width(mem_width), .mem_misalign(mem_misalign), .mem_illegal(mem_illegal)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string mtag(input int m);
    case (m)
      0, 1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5, 6: return "R6";
      7, 8: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic load(input int kind, input int idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_kind = 2'(kind); wr_idx = 3'(idx); wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
    if (kind == 0) sa[idx] = d;
    else if (kind == 1) sn[idx] = d;
    else ssp = d;
  endtask

  // One request; expected values from the requirements; shadow updated on transfer.
  task automatic op(input int m, input int w, input int a, input int rm, input int ni,
                    input logic [7:0] ds, input logic [15:0] dw, input bit rdy, input bit spw);
    logic [31:0] sz, ea, nx, dsx, dwx;
    bit ill, wba, wbs;
    string t;
    t = mtag(m);
    sz = 32'd1 << w;
    dsx = {{24{ds[7]}}, ds};
    dwx = {{16{dw[15]}}, dw};
    ill = 0; wba = 0; wbs = 0; ea = sa[a]; nx = 0;
    case (m)
      0: begin nx = sa[a] + sz; wba = 1; end
      1: begin nx = sa[a] - sz; wba = 1; end
      2: begin nx = sa[a] + sn[ni] * sz; wba = 1; end
      3: ea = sa[a] + sn[0] * sz;
      4: ea = sa[rm] * sz + sa[a];
      5: ea = sa[a] + dsx;
      6: ea = sa[a] + dwx;
      7: begin ea = ssp; nx = ssp + 32'd8; wbs = 1; end
      8: begin ea = ssp - 32'd8; nx = ea; wbs = 1; end
      9: begin ea = ssp - {24'd0, ds}; ill = (w == 0 || w == 3); end
      10: ea = ssp + dwx;
      default: ill = 1;
    endcase
    @(negedge clk);
    req_valid = 1; req_mode = 4'(m); req_width = 2'(w); req_areg = 3'(a);
    req_rm = 3'(rm); req_ni = 2'(ni); req_disp_s = ds; req_disp_w = dw; mem_ready = rdy;
    if (spw) begin wr_en = 1; wr_kind = 2; wr_idx = 0; wr_data = 32'h0000_0100; end
    #1;
    chk("R10 ready", 32'(req_ready), 32'(rdy));
    chk("R8 illegal", 32'(mem_illegal), 32'(ill));
    chk("R8 mem_valid", 32'(mem_valid), 32'(!ill));
    chk("R1 strobe", 32'(mem_width), 32'(sz));
    if (!ill) begin
      chk(t, mem_addr, ea);
      chk("R9 misalign", 32'(mem_misalign), 32'((ea % sz) != 0));
    end else chk("R9 misalign", 32'(mem_misalign), 32'd0);
    @(posedge clk); #1;
    req_valid = 0; mem_ready = 1; wr_en = 0;
    if (rdy && !ill && wba) sa[a] = nx;
    if (rdy && !ill && wbs) ssp = nx;
    if (spw) ssp = 32'h0000_0100;
  endtask

  // Zero-displacement reads that bring a pointer out through mem_addr.
  task automatic peek_a(input string tag, input int a);
    @(negedge clk);
    req_valid = 1; req_mode = 4'd5; req_width = 0; req_areg = 3'(a); req_disp_s = 0;
    #1; chk(tag, mem_addr, sa[a]);
    @(posedge clk); #1; req_valid = 0;
  endtask

  task automatic peek_sp(input string tag);
    @(negedge clk);
    req_valid = 1; req_mode = 4'd10; req_width = 0; req_disp_w = 0;
    #1; chk(tag, mem_addr, ssp);
    @(posedge clk); #1; req_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) sa[i] = 0;
    for (int i = 0; i < 4; i++) sn[i] = 0;
    ssp = 0;
    #(CLK_P * 3); rst_n = 1;
    #1;
    chk("R1 idle strobe", 32'(mem_width), 32'd0);
    // R12: registers come out of reset at zero
    for (int i = 0; i < 8; i++) peek_a("R12 areg", i);
    peek_sp("R12 sp");
    op(3, 0, 0, 0, 0, 8'd0, 16'd0, 1, 0);

    load(1, 0, 32'd3); load(1, 1, 32'hFFFF_FFFF); load(1, 2, 32'd5); load(1, 3, 32'd2);
    for (int w = 0; w < 4; w++)
      for (int m = 0; m < 11; m++)
        for (int o = 0; o < 4; o++) begin
          int a, rm;
          a = (m + o) % 8; rm = (a + 1) % 8;
          load(0, a, 32'h0000_1000 + 32'(o) * 32'h11);
          load(0, rm, 32'(o * 3 + 1));
          load(2, 0, 32'h0000_2000 + 32'(o));
          op(m, w, a, rm, o, (o[0] ? 8'hF3 : 8'h06), (o[1] ? 16'h8001 : 16'h0102), 1, 0);
          peek_a({mtag(m), " wb"}, a);
          peek_sp({mtag(m), " sp wb"});
        end

    // R8: unknown mode codes are illegal and leave registers alone
    for (int m = 11; m < 16; m++) begin
      op(m, 1, 2, 0, 0, 8'd0, 16'd0, 1, 0);
      peek_a("R8 no wb", 2);
    end
    // R10: stalled post-increment and push change nothing
    load(0, 4, 32'h0000_0040);
    op(0, 2, 4, 0, 0, 8'd0, 16'd0, 0, 0);
    peek_a("R10 stall areg", 4);
    op(7, 2, 4, 0, 0, 8'd0, 16'd0, 0, 0);
    peek_sp("R10 stall sp");
    // R11: stack pointer load beats a push on the same edge
    load(2, 0, 32'h0000_0800);
    op(7, 3, 0, 0, 0, 8'd0, 16'd0, 1, 1);
    peek_sp("R11 collision");
    // R13: wrap-around on increment and pop
    load(0, 5, 32'hFFFF_FFFC);
    op(0, 3, 5, 0, 0, 8'd0, 16'd0, 1, 0);
    peek_a("R13 wrap inc", 5);
    load(2, 0, 32'd0);
    op(8, 1, 0, 0, 0, 8'd0, 16'd0, 1, 0);
    peek_sp("R13 wrap pop");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule